// File: doc/BRIEF.md
# MESI Snooping Line Controller

This block is the coherence controller of one small direct-mapped cache that sits on a shared snooping bus. It keeps a tag and a two-bit coherence state (Invalid, Shared, Exclusive, Modified) for every line, serves processor reads and writes, and asks for the bus when an access cannot be completed locally. It also watches the transactions of the other caches on the bus and changes its own copies to match. No line data is held here; the block decides which bus transaction is needed and what the line state becomes.

A processor access is accepted when `req_ready_o` is high. Reads of any valid copy, and writes to a line held Exclusive or Modified, complete without the bus. All other accesses raise `bus_req_o` with a command and an address until `bus_gnt_i` arrives. For a read fetch, the wired-OR shared line sampled in the grant cycle decides between Exclusive and Shared. A conflict miss over a Modified line first writes the old line back. The arbiter never grants this cache in a cycle in which another cache's transaction is presented on the snoop port.

A snooped transaction is either a read or an intent to write. When it hits a valid line, the block drives `snp_shared_o` in the same cycle. When the line is Modified it also pulses `snp_flush_o` to supply or write back the data. The new state is applied at the following clock edge.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid: `req_ready_o` is high, `bus_req_o` and `rsp_valid_o` are low, and the first access to any address misses.
- R2: A read miss issues bus command 0 (fetch shared) at the request address. The line becomes Exclusive when `bus_shared_i` is low in the grant cycle and Shared when it is high.
- R3: A write miss issues bus command 1 (fetch for ownership) at the request address. The line ends Modified.
- R4: A write to an Exclusive line completes without any bus request and leaves the line Modified.
- R5: A write to a Shared line issues bus command 2 (ownership upgrade) and ends Modified.
- R6: A read that hits any valid line, and a write that hits a Modified line, complete without a bus request and leave the state unchanged.
- R7: A snooped read (`snp_itw_i`=0) that hits a Modified line drives `snp_shared_o` and `snp_flush_o` in the same cycle, and the line becomes Shared.
- R8: A snooped intent to write (`snp_itw_i`=1) that hits a Modified line drives `snp_flush_o` and `snp_shared_o`, and the line becomes Invalid.
- R9: A snooped read that hits an Exclusive line makes it Shared. A snooped intent to write that hits a Shared or Exclusive line makes it Invalid. Both drive `snp_shared_o`, and neither drives `snp_flush_o`.
- R10: A snoop whose tag differs from the stored tag, or whose line is Invalid, drives neither output and leaves the line unchanged.
- R11: A miss whose index holds a Modified line with another tag first issues bus command 3 (write-back) at the victim's address `{stored tag, index}`, then issues the fetch. Exclusive and Shared victims are replaced without a write-back.
- R12: While a request waits for the bus, its command is derived again from the current line state. An upgrade whose Shared copy is invalidated by a snoop becomes a fetch for ownership. A Modified victim that a snoop flushed needs no write-back.
- R13: `req_ready_o` is low while a request is outstanding on the bus, and also in any cycle in which a valid snoop targets the same index as `req_addr_i`.
- R14: `rsp_valid_o` pulses one cycle after the clock edge that completes an access. `rsp_hit_o` is 1 when the access used no bus transaction and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Processor access request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Line address of the access |
| req_ready_o | output | 1 | Access accepted in this cycle when high with req_valid_i |
| rsp_valid_o | output | 1 | Access completed (one-cycle pulse) |
| rsp_hit_o | output | 1 | Completed access needed no bus transaction |
| bus_req_o | output | 1 | Bus request, held until granted |
| bus_cmd_o | output | 2 | 0 fetch shared, 1 fetch for ownership, 2 upgrade, 3 write-back |
| bus_addr_o | output | ADDR_W | Line address of the bus command |
| bus_gnt_i | input | 1 | Bus grant; the command takes effect at this edge |
| bus_shared_i | input | 1 | Wired-OR shared line from the other caches |
| snp_valid_i | input | 1 | Another cache's transaction is on the bus |
| snp_itw_i | input | 1 | 1 = intent to write, 0 = read |
| snp_addr_i | input | ADDR_W | Line address of the snooped transaction |
| snp_shared_o | output | 1 | This cache holds a valid copy of the snooped line |
| snp_flush_o | output | 1 | This cache supplies or writes back a Modified line |

## Verification
The bench drives a long mixed stream of processor accesses and snoops over four indices and eight tags. A bench-side state model predicts every hit, every bus command and address, and every snoop response. If the shared-line sampling were wrong, a line would come back Exclusive instead of Shared, and a later write would miss its upgrade. If Modified victims were not written back, or clean victims were, the command sequence would differ. If snoop hits were matched on index alone, a foreign tag would set `snp_shared_o`. Directed cases cover the snoop that arrives while a request waits for the bus: a design that latched its command at acceptance would send an upgrade for a line it no longer holds, or write back a line already flushed. They also cover the same-index stall: a design that ignored it would let a processor write and a snoop update the same line at the same edge.

// File: rtl/mesi_coh_pkg.sv
package mesi_coh_pkg;
  typedef enum logic [1:0] {ST_I = 2'd0, ST_S = 2'd1, ST_E = 2'd2, ST_M = 2'd3} mesi_e;
  typedef enum logic [1:0] {BC_RD = 2'd0, BC_RDX = 2'd1, BC_UPG = 2'd2, BC_WB = 2'd3} bus_cmd_e;
  typedef enum logic {FS_IDLE = 1'b0, FS_BUSY = 1'b1} fsm_e;

  // state left behind by a snoop hit
  function automatic mesi_e snoop_next(input mesi_e cur, input logic itw);
    if (cur == ST_I || itw) return ST_I;
    return ST_S;
  endfunction
endpackage

// File: rtl/mesi_tag_store.sv
module mesi_tag_store
  import mesi_coh_pkg::*;
#(
  parameter int IDX_W = 4,
  parameter int TAG_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] prc_ridx_i,
  output mesi_e            prc_rstate_o,
  output logic [TAG_W-1:0] prc_rtag_o,
  input  logic [IDX_W-1:0] snp_ridx_i,
  output mesi_e            snp_rstate_o,
  output logic [TAG_W-1:0] snp_rtag_o,
  input  logic             prc_we_i,
  input  logic [IDX_W-1:0] prc_widx_i,
  input  mesi_e            prc_wstate_i,
  input  logic [TAG_W-1:0] prc_wtag_i,
  input  logic             snp_we_i,
  input  logic [IDX_W-1:0] snp_widx_i,
  input  mesi_e            snp_wstate_i
);
  localparam int NUM_LINES = 1 << IDX_W;

  mesi_e            st_q  [NUM_LINES];
  logic [TAG_W-1:0] tag_q [NUM_LINES];

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        st_q[g]  <= ST_I;
        tag_q[g] <= '0;
      end else if (snp_we_i && snp_widx_i == IDX_W'(g)) begin
        st_q[g] <= snp_wstate_i;
      end else if (prc_we_i && prc_widx_i == IDX_W'(g)) begin
        st_q[g]  <= prc_wstate_i;
        tag_q[g] <= prc_wtag_i;
      end
    end
  end

  assign prc_rstate_o = st_q[prc_ridx_i];
  assign prc_rtag_o   = tag_q[prc_ridx_i];
  assign snp_rstate_o = st_q[snp_ridx_i];
  assign snp_rtag_o   = tag_q[snp_ridx_i];
endmodule

// File: rtl/mesi_snoop_unit.sv
module mesi_snoop_unit
  import mesi_coh_pkg::*;
#(
  parameter int TAG_W = 12
) (
  input  logic             snp_valid_i,
  input  logic             snp_itw_i,
  input  logic [TAG_W-1:0] snp_tag_i,
  input  mesi_e            line_state_i,
  input  logic [TAG_W-1:0] line_tag_i,
  output logic             shared_o,
  output logic             flush_o,
  output logic             upd_en_o,
  output mesi_e            upd_state_o
);
  logic hit;

  always_comb begin
    hit         = snp_valid_i && (line_state_i != ST_I) && (line_tag_i == snp_tag_i);
    shared_o    = hit;
    flush_o     = hit && (line_state_i == ST_M);
    upd_en_o    = hit;
    upd_state_o = snoop_next(line_state_i, snp_itw_i);
  end
endmodule

// File: rtl/mesi_req_fsm.sv
module mesi_req_fsm
  import mesi_coh_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 4,
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              snp_block_i,
  output logic              req_ready_o,
  output logic              rsp_valid_o,
  output logic              rsp_hit_o,
  output logic              bus_req_o,
  output bus_cmd_e          bus_cmd_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  input  logic              bus_gnt_i,
  input  logic              bus_shared_i,
  output logic [IDX_W-1:0]  lookup_idx_o,
  input  mesi_e             line_state_i,
  input  logic [TAG_W-1:0]  line_tag_i,
  output logic              wr_en_o,
  output logic [IDX_W-1:0]  wr_idx_o,
  output mesi_e             wr_state_o,
  output logic [TAG_W-1:0]  wr_tag_o
);
  fsm_e              fsm_q;
  logic              lat_write_q;
  logic [ADDR_W-1:0] lat_addr_q;
  logic              rsp_valid_q, rsp_hit_q;

  logic              busy, cur_write, line_hit, need_bus, accept, grant, done;
  logic [ADDR_W-1:0] cur_addr;
  logic [IDX_W-1:0]  cur_idx;
  logic [TAG_W-1:0]  cur_tag;
  bus_cmd_e          cmd;

  always_comb begin
    busy      = (fsm_q == FS_BUSY);
    cur_write = busy ? lat_write_q : req_write_i;
    cur_addr  = busy ? lat_addr_q : req_addr_i;
    cur_idx   = cur_addr[IDX_W-1:0];
    cur_tag   = cur_addr[ADDR_W-1:IDX_W];
    line_hit  = (line_state_i != ST_I) && (line_tag_i == cur_tag);

    // command derived from the live line state every cycle
    need_bus = 1'b1;
    cmd      = BC_RD;
    if (!line_hit && line_state_i == ST_M) cmd = BC_WB;
    else if (cur_write) begin
      if (line_hit && line_state_i == ST_S) cmd = BC_UPG;
      else if (line_hit) need_bus = 1'b0;
      else cmd = BC_RDX;
    end else if (line_hit) need_bus = 1'b0;

    req_ready_o = !busy && !snp_block_i;
    accept      = req_valid_i && req_ready_o;
    grant       = busy && bus_gnt_i;

    wr_en_o    = 1'b0;
    wr_idx_o   = cur_idx;
    wr_state_o = line_state_i;
    wr_tag_o   = cur_tag;
    if (accept && !need_bus && cur_write) begin
      wr_en_o    = 1'b1;
      wr_state_o = ST_M;
    end
    if (grant) begin
      wr_en_o = 1'b1;
      unique case (cmd)
        BC_WB:  begin wr_state_o = ST_I; wr_tag_o = line_tag_i; end
        BC_RD:  wr_state_o = bus_shared_i ? ST_S : ST_E;
        default: wr_state_o = ST_M;
      endcase
    end
    done = (accept && !need_bus) || (grant && cmd != BC_WB);
  end

  assign lookup_idx_o = cur_idx;
  assign bus_req_o    = busy;
  assign bus_cmd_o    = cmd;
  assign bus_addr_o   = (cmd == BC_WB) ? {line_tag_i, cur_idx} : cur_addr;
  assign rsp_valid_o  = rsp_valid_q;
  assign rsp_hit_o    = rsp_hit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fsm_q       <= FS_IDLE;
      lat_write_q <= 1'b0;
      lat_addr_q  <= '0;
      rsp_valid_q <= 1'b0;
      rsp_hit_q   <= 1'b0;
    end else begin
      rsp_valid_q <= done;
      rsp_hit_q   <= accept && !need_bus;
      if (!busy) begin
        if (accept && need_bus) begin
          fsm_q       <= FS_BUSY;
          lat_write_q <= req_write_i;
          lat_addr_q  <= req_addr_i;
        end
      end else if (grant && cmd != BC_WB) begin
        fsm_q <= FS_IDLE;
      end
    end
  end
endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
  import mesi_coh_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              req_ready_o,
  output logic              rsp_valid_o,
  output logic              rsp_hit_o,
  output logic              bus_req_o,
  output logic [1:0]        bus_cmd_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  input  logic              bus_gnt_i,
  input  logic              bus_shared_i,
  input  logic              snp_valid_i,
  input  logic              snp_itw_i,
  input  logic [ADDR_W-1:0] snp_addr_i,
  output logic              snp_shared_o,
  output logic              snp_flush_o
);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0] lookup_idx, snp_idx;
  logic [TAG_W-1:0] snp_tag;
  mesi_e            prc_state, snp_state, wr_state, snp_upd_state;
  logic [TAG_W-1:0] prc_tag, snp_line_tag, wr_tag;
  logic [IDX_W-1:0] wr_idx;
  logic             wr_en, snp_upd_en, snp_block;
  bus_cmd_e         cmd;

  assign snp_idx   = snp_addr_i[IDX_W-1:0];
  assign snp_tag   = snp_addr_i[ADDR_W-1:IDX_W];
  assign snp_block = snp_valid_i && (snp_idx == req_addr_i[IDX_W-1:0]);
  assign bus_cmd_o = cmd;

  mesi_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_store (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .prc_ridx_i   (lookup_idx),
    .prc_rstate_o (prc_state),
    .prc_rtag_o   (prc_tag),
    .snp_ridx_i   (snp_idx),
    .snp_rstate_o (snp_state),
    .snp_rtag_o   (snp_line_tag),
    .prc_we_i     (wr_en),
    .prc_widx_i   (wr_idx),
    .prc_wstate_i (wr_state),
    .prc_wtag_i   (wr_tag),
    .snp_we_i     (snp_upd_en),
    .snp_widx_i   (snp_idx),
    .snp_wstate_i (snp_upd_state)
  );

  mesi_snoop_unit #(.TAG_W(TAG_W)) u_snoop (
    .snp_valid_i  (snp_valid_i),
    .snp_itw_i    (snp_itw_i),
    .snp_tag_i    (snp_tag),
    .line_state_i (snp_state),
    .line_tag_i   (snp_line_tag),
    .shared_o     (snp_shared_o),
    .flush_o      (snp_flush_o),
    .upd_en_o     (snp_upd_en),
    .upd_state_o  (snp_upd_state)
  );

  mesi_req_fsm #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_valid_i  (req_valid_i),
    .req_write_i  (req_write_i),
    .req_addr_i   (req_addr_i),
    .snp_block_i  (snp_block),
    .req_ready_o  (req_ready_o),
    .rsp_valid_o  (rsp_valid_o),
    .rsp_hit_o    (rsp_hit_o),
    .bus_req_o    (bus_req_o),
    .bus_cmd_o    (cmd),
    .bus_addr_o   (bus_addr_o),
    .bus_gnt_i    (bus_gnt_i),
    .bus_shared_i (bus_shared_i),
    .lookup_idx_o (lookup_idx),
    .line_state_i (prc_state),
    .line_tag_i   (prc_tag),
    .wr_en_o      (wr_en),
    .wr_idx_o     (wr_idx),
    .wr_state_o   (wr_state),
    .wr_tag_o     (wr_tag)
  );
endmodule

// File: rtl/mesi_line_ctrl_chk.sv
module mesi_line_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_valid_i,
  input logic       req_ready_o,
  input logic       rsp_valid_o,
  input logic       rsp_hit_o,
  input logic       bus_req_o,
  input logic [1:0] bus_cmd_o,
  input logic       bus_gnt_i,
  input logic       snp_valid_i,
  input logic       snp_shared_o,
  input logic       snp_flush_o
);
  // R13
  busy_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |-> !req_ready_o);

  // R7
  flush_shared_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_flush_o |-> snp_shared_o);

  // R10
  idle_snoop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !snp_valid_i |-> (!snp_shared_o && !snp_flush_o));

  // R14
  rsp_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $past((req_valid_i && req_ready_o) || (bus_req_o && bus_gnt_i)));

  // R14
  hit_no_bus_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_hit_o) |-> !$past(bus_req_o));

  // R2
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_gnt_i) |=> bus_req_o);

  // R11
  wb_then_fetch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && bus_gnt_i && bus_cmd_o == 2'd3) |=> (bus_req_o && bus_cmd_o != 2'd3));
endmodule

bind mesi_line_ctrl mesi_line_ctrl_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .req_ready_o  (req_ready_o),
  .rsp_valid_o  (rsp_valid_o),
  .rsp_hit_o    (rsp_hit_o),
  .bus_req_o    (bus_req_o),
  .bus_cmd_o    (bus_cmd_o),
  .bus_gnt_i    (bus_gnt_i),
  .snp_valid_i  (snp_valid_i),
  .snp_shared_o (snp_shared_o),
  .snp_flush_o  (snp_flush_o)
);

// File: tb/sim_mesi_line_ctrl.sv
`timescale 1ns/1ps
module sim_mesi_line_ctrl;
  localparam int AW = 5;
  localparam int IW = 2;
  localparam int NL = 1 << IW;
  // model encodings
  localparam int MI = 0, MS = 1, ME = 2, MM = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_write = 0, bus_gnt = 0, bus_shared = 0;
  logic snp_valid = 0, snp_itw = 0;
  logic [AW-1:0] req_addr = '0, snp_addr = '0;
  logic req_ready, rsp_valid, rsp_hit, bus_req, snp_shared, snp_flush;
  logic [1:0] bus_cmd;
  logic [AW-1:0] bus_addr;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;
  int m_st [NL];
  int m_tg [NL];
  int unsigned rng = 32'h1234_5678;

  always #2 clk = ~clk;

  mesi_line_ctrl #(.ADDR_W(AW), .IDX_W(IW)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_write_i(req_write), .req_addr_i(req_addr),
    .req_ready_o(req_ready), .rsp_valid_o(rsp_valid), .rsp_hit_o(rsp_hit),
    .bus_req_o(bus_req), .bus_cmd_o(bus_cmd), .bus_addr_o(bus_addr),
    .bus_gnt_i(bus_gnt), .bus_shared_i(bus_shared),
    .snp_valid_i(snp_valid), .snp_itw_i(snp_itw), .snp_addr_i(snp_addr),
    .snp_shared_o(snp_shared), .snp_flush_o(snp_flush)
  );

  task automatic chk(input string rq, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  function automatic int unsigned nxt();
    rng ^= rng << 13; rng ^= rng >> 17; rng ^= rng << 5;
    return rng;
  endfunction

  // one bus grant: check the pending command, grant with the given shared value
  task automatic bus_step(input int cmd, input int addr, input bit sh, input string rq);
    @(negedge clk);
    chk({rq, " bus_req"}, int'(bus_req), 1);
    chk({rq, " bus_cmd"}, int'(bus_cmd), cmd);
    chk({rq, " bus_addr"}, int'(bus_addr), addr);
    chk("R13 ready while busy", int'(req_ready), 0);
    bus_gnt = 1; bus_shared = sh;
    @(posedge clk); #1;
    bus_gnt = 0; bus_shared = 0;
  endtask

  task automatic proc_op(input bit wr, input int addr, input bit sh);
    int idx, tg, st, cmd;
    bit hit;
    string rq;
    idx = addr % NL; tg = addr / NL; st = m_st[idx];
    hit = (st != MI) && (m_tg[idx] == tg);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = AW'(addr);
    #0.5;
    chk("R13 ready idle", int'(req_ready), 1);
    @(posedge clk); #1;
    req_valid = 0;
    if (hit && (!wr || st != MS)) begin
      rq = wr ? ((st == ME) ? "R4 write hit E" : "R6 write hit M") : "R6 read hit";
      chk({rq, " rsp_valid"}, int'(rsp_valid), 1);
      chk({rq, " rsp_hit (R14)"}, int'(rsp_hit), 1);
      chk({rq, " no bus"}, int'(bus_req), 0);
      if (wr) m_st[idx] = MM;
    end else begin
      if (!hit && st == MM) begin
        bus_step(3, m_tg[idx] * NL + idx, 0, "R11 evict");
        m_st[idx] = MI; st = MI;
      end
      if (wr) begin
        cmd = (hit && st == MS) ? 2 : 1;
        rq = (cmd == 2) ? "R5 upgrade" : "R3 write miss";
      end else begin
        cmd = 0;
        rq = sh ? "R2 read miss shared" : "R2 read miss excl";
      end
      bus_step(cmd, addr, sh, rq);
      chk({rq, " rsp_valid (R14)"}, int'(rsp_valid), 1);
      chk({rq, " rsp_hit (R14)"}, int'(rsp_hit), 0);
      m_tg[idx] = tg;
      m_st[idx] = wr ? MM : (sh ? MS : ME);
    end
  endtask

  function automatic string snp_rq(input int st, input bit hit, input bit itw);
    if (!hit) return "R10 snoop miss";
    if (st == MM) return itw ? "R8 snoop itw M" : "R7 snoop read M";
    return "R9 snoop E/S";
  endfunction

  // apply snoop outputs expectation and model update (call with snoop driven)
  task automatic snp_check_update(input int addr, input bit itw);
    int idx, st;
    bit hit;
    string rq;
    idx = addr % NL; st = m_st[idx];
    hit = (st != MI) && (m_tg[idx] == addr / NL);
    rq = snp_rq(st, hit, itw);
    chk({rq, " shared"}, int'(snp_shared), int'(hit));
    chk({rq, " flush"}, int'(snp_flush), int'(hit && st == MM));
    if (hit) m_st[idx] = itw ? MI : MS;
  endtask

  task automatic snoop_op(input bit itw, input int addr);
    @(negedge clk);
    snp_valid = 1; snp_itw = itw; snp_addr = AW'(addr);
    #0.5;
    snp_check_update(addr, itw);
    @(posedge clk); #1;
    snp_valid = 0;
  endtask

  initial begin
    for (int i = 0; i < NL; i++) begin m_st[i] = MI; m_tg[i] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R1 reset ready", int'(req_ready), 1);
    chk("R1 reset bus_req", int'(bus_req), 0);
    chk("R1 reset rsp_valid", int'(rsp_valid), 0);

    // R1 / R2 / R4 / R6
    proc_op(0, 5'h01, 0);      // miss -> E
    proc_op(1, 5'h01, 0);      // E write -> M, no bus
    proc_op(0, 5'h01, 0);      // read hit M
    proc_op(0, 5'h02, 1);      // miss shared -> S
    proc_op(1, 5'h02, 0);      // upgrade
    proc_op(1, 5'h13, 0);      // write miss -> M
    snoop_op(0, 5'h13);        // R7
    snoop_op(1, 5'h01);        // R8
    snoop_op(0, 5'h17);        // R10 tag mismatch on index 3
    proc_op(0, 5'h13, 0);      // still S: hit
    proc_op(1, 5'h05, 0);      // write miss on idx1 (I)
    proc_op(0, 5'h09, 0);      // R11 M victim written back

    // R13: snoop on same index blocks the request
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = 5'h0A;
    snp_valid = 1; snp_itw = 0; snp_addr = 5'h1E;
    #0.5;
    chk("R13 snoop same index stall", int'(req_ready), 0);
    snp_check_update(5'h1E, 0);
    req_valid = 0;
    @(posedge clk); #1;
    snp_valid = 0;

    // R12: upgrade turned into ownership fetch by a snoop while waiting
    proc_op(0, 5'h0B, 1);      // idx3 S
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = 5'h0B;
    @(posedge clk); #1;
    req_valid = 0;
    @(negedge clk);
    chk("R12 pending upgrade cmd", int'(bus_cmd), 2);
    snp_valid = 1; snp_itw = 1; snp_addr = 5'h0B;
    #0.5;
    chk("R12 snoop on pending line shared", int'(snp_shared), 1);
    @(posedge clk); #1;
    snp_valid = 0;
    m_st[3] = MI;
    bus_step(1, 5'h0B, 0, "R12 re-derived fetch for ownership");
    chk("R12 rsp_valid", int'(rsp_valid), 1);
    m_st[3] = MM; m_tg[3] = 2;

    // R12: Modified victim flushed by a snoop needs no write-back
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = 5'h0F;
    @(posedge clk); #1;
    req_valid = 0;
    @(negedge clk);
    chk("R12 pending write-back cmd", int'(bus_cmd), 3);
    snp_valid = 1; snp_itw = 0; snp_addr = 5'h0B;
    #0.5;
    chk("R12 victim flush", int'(snp_flush), 1);
    @(posedge clk); #1;
    snp_valid = 0;
    bus_step(0, 5'h0F, 0, "R12 no write-back after flush");
    chk("R12 rsp_valid after fetch", int'(rsp_valid), 1);
    m_st[3] = ME; m_tg[3] = 3;

    // mixed sweep against the model
    for (int k = 0; k < 3000; k++) begin
      int unsigned r;
      r = nxt();
      case (r[1:0])
        2'd0: proc_op(0, int'(r[8:4]), r[12]);
        2'd1: proc_op(1, int'(r[8:4]), r[12]);
        2'd2: snoop_op(0, int'(r[8:4]));
        default: snoop_op(1, int'(r[8:4]));
      endcase
    end

    // final sweep of every address: read to expose each state
    for (int a = 0; a < (1 << AW); a++) proc_op(0, a, a[0]);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule